// File: doc/BRIEF.md
# Binary Block Matching Cost Unit

This unit scores how well one 16x16 candidate block from a motion search window matches the 16x16 block being coded, with both blocks reduced to a single bit per pixel. Every pixel pair is compared with an exclusive-OR, so a differing pixel costs one and an equal pixel costs nothing. The mismatches of each 16-pixel row are counted, and the sixteen row counts are added into one 9-bit total. A smaller total means a closer match. The search controller that owns the unit can therefore rank candidates by this number.

The unit is a two-stage pipeline. The first stage counts the mismatches of each row and registers the sixteen counts. The second stage adds them and registers the total. A candidate may be presented on every clock cycle. Its cost comes out two cycles later, together with a valid flag. Memory fetch, minimum tracking and candidate selection belong to the surrounding search logic.

Top module: `bbm_cost_unit`

## Requirements
- R1: Pixel (row r, column c) is bit r*16+c of each block vector. The cost is the number of bit positions at which `cur_blk` and `cand_blk` differ.
- R2: Identical blocks give a cost of 0. Fully complementary blocks give the maximum cost of 256.
- R3: The cost is the sum of sixteen row counts, each ranging from 0 to 16. A single row in which all 16 pixels differ, with every other row matching, gives exactly 16.
- R4: `cost` is 9 bits wide and never exceeds 256.
- R5: When `in_valid` is high at a rising clock edge, `cost_valid` is high after the second rising edge that follows. At that point `cost` holds the result for the blocks sampled with that strobe.
- R6: A candidate is accepted on every cycle that `in_valid` is high. Back-to-back candidates produce back-to-back results, in order, each with its own cost.
- R7: Block inputs sampled while `in_valid` is low are ignored. `cost_valid` stays low for them, and `cost` keeps the last result it produced.
- R8: Reset is synchronous and active high. It clears both pipeline valid flags and the cost to 0. A strobe given during reset produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Candidate strobe; the block inputs are sampled when it is high |
| cur_blk | input | 256 | Current block, one bit per pixel, row-major |
| cand_blk | input | 256 | Candidate block from the search window, same layout |
| cost_valid | output | 1 | High for one cycle per accepted candidate, two cycles after its strobe |
| cost | output | 9 | Mismatch count of the candidate, 0 to 256 |

## Verification
Accepting a new candidate and delivering the cost of an earlier one happen in the same cycle whenever strobes come back to back. The table walk therefore drives one vector per cycle without a gap. Each cost is judged against the table entry presented two cycles before it, so any mixing of neighbouring candidates shows up as a wrong value. A second overlap, a strobe that coincides with reset, is provoked by holding `in_valid` high through reset. It is judged by checking that no result appears after release.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    localparam int unsigned BBM_DEF_DIM = 16;

    function automatic int unsigned bbm_cnt_width(input int unsigned max_val);
        return $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/bbm_row_match.sv
module bbm_row_match #(
    parameter int unsigned W  = 16,
    parameter int unsigned CW = bbm_pkg::bbm_cnt_width(W)
) (
    input  logic [W-1:0]  row_a,
    input  logic [W-1:0]  row_b,
    output logic [CW-1:0] mism
);
    logic [W-1:0] diff;

    assign diff = row_a ^ row_b;

    always_comb begin
        mism = '0;
        for (int i = 0; i < int'(W); i++) begin
            mism = mism + CW'(diff[i]);
        end
    end
endmodule

// File: rtl/bbm_row_stage.sv
module bbm_row_stage #(
    parameter int unsigned DIM = 16,
    parameter int unsigned CW  = bbm_pkg::bbm_cnt_width(DIM)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [DIM*DIM-1:0]       cur_blk,
    input  logic [DIM*DIM-1:0]       cand_blk,
    output logic                     rows_valid,
    output logic [DIM-1:0][CW-1:0]   row_cnt
);
    logic [DIM-1:0][CW-1:0] row_cnt_d;

    for (genvar r = 0; r < DIM; r++) begin : g_row
        bbm_row_match #(.W(DIM), .CW(CW)) u_match (
            .row_a (cur_blk[r*DIM +: DIM]),
            .row_b (cand_blk[r*DIM +: DIM]),
            .mism  (row_cnt_d[r])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_valid <= 1'b0;
            row_cnt    <= '0;
        end else begin
            rows_valid <= in_valid;
            if (in_valid) begin
                row_cnt <= row_cnt_d;
            end
        end
    end
endmodule

// File: rtl/bbm_sum_stage.sv
module bbm_sum_stage #(
    parameter int unsigned DIM = 16,
    parameter int unsigned CW  = bbm_pkg::bbm_cnt_width(DIM),
    parameter int unsigned TW  = bbm_pkg::bbm_cnt_width(DIM*DIM)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rows_valid,
    input  logic [DIM-1:0][CW-1:0] row_cnt,
    output logic                   sum_valid,
    output logic [TW-1:0]          sum
);
    logic [TW-1:0] sum_d;

    always_comb begin
        sum_d = '0;
        for (int r = 0; r < int'(DIM); r++) begin
            sum_d = sum_d + TW'(row_cnt[r]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_valid <= 1'b0;
            sum       <= '0;
        end else begin
            sum_valid <= rows_valid;
            if (rows_valid) begin
                sum <= sum_d;
            end
        end
    end
endmodule

// File: rtl/bbm_cost_unit.sv
module bbm_cost_unit #(
    parameter int unsigned DIM = bbm_pkg::BBM_DEF_DIM
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [DIM*DIM-1:0]    cur_blk,
    input  logic [DIM*DIM-1:0]    cand_blk,
    output logic                  cost_valid,
    output logic [bbm_pkg::bbm_cnt_width(DIM*DIM)-1:0] cost
);
    localparam int unsigned CW = bbm_pkg::bbm_cnt_width(DIM);
    localparam int unsigned TW = bbm_pkg::bbm_cnt_width(DIM*DIM);

    logic                   rows_valid;
    logic [DIM-1:0][CW-1:0] row_cnt;

    bbm_row_stage #(.DIM(DIM), .CW(CW)) u_rows (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .cur_blk    (cur_blk),
        .cand_blk   (cand_blk),
        .rows_valid (rows_valid),
        .row_cnt    (row_cnt)
    );

    bbm_sum_stage #(.DIM(DIM), .CW(CW), .TW(TW)) u_sum (
        .clk        (clk),
        .rst        (rst),
        .rows_valid (rows_valid),
        .row_cnt    (row_cnt),
        .sum_valid  (cost_valid),
        .sum        (cost)
    );
endmodule

// File: rtl/bbm_cost_unit_chk.sv
module bbm_cost_unit_chk #(
    parameter int unsigned DIM = bbm_pkg::BBM_DEF_DIM
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [DIM*DIM-1:0]    cur_blk,
    input logic [DIM*DIM-1:0]    cand_blk,
    input logic                  cost_valid,
    input logic [bbm_pkg::bbm_cnt_width(DIM*DIM)-1:0] cost
);
    localparam int unsigned TW = bbm_pkg::bbm_cnt_width(DIM*DIM);

    logic               sv1, sv2;
    logic [DIM*DIM-1:0] sd1, sd2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sv1 <= 1'b0;
            sv2 <= 1'b0;
        end else begin
            sv1 <= in_valid;
            sv2 <= sv1;
        end
        sd1 <= cur_blk ^ cand_blk;
        sd2 <= sd1;
    end

    // R5, R6: a result appears exactly two cycles after each strobe
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        cost_valid == sv2);

    // R1, R2, R3: the result equals the mismatch count of its own candidate
    assert_exact_cost_R1: assert property (@(posedge clk) disable iff (rst)
        cost_valid |-> (cost == TW'($countones(sd2))));

    // R4: the cost stays within the block's pixel count
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        cost <= TW'(DIM*DIM));

    // R7: without a result the cost holds its value
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !cost_valid |-> $stable(cost));

    // R8: reset clears the valid flag and the cost
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!cost_valid && cost == '0));
endmodule

bind bbm_cost_unit bbm_cost_unit_chk #(.DIM(DIM)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .cur_blk    (cur_blk),
    .cand_blk   (cand_blk),
    .cost_valid (cost_valid),
    .cost       (cost)
);

// File: tb/bbm_cost_unit_test.sv
`timescale 1ns/1ps
module bbm_cost_unit_test;
    localparam int DIM = 16;
    localparam int NB  = DIM * DIM;

    typedef struct packed {
        logic [15:0] prow;
        logic [15:0] drow;
        logic [15:0] rmask;
        logic [8:0]  exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{16'h0000, 16'h0000, 16'hFFFF, 9'd0},
        '{16'hFFFF, 16'h0000, 16'hFFFF, 9'd256},
        '{16'hAAAA, 16'h5555, 16'hFFFF, 9'd256},
        '{16'hAAAA, 16'hAAAB, 16'hFFFF, 9'd16},
        '{16'h0000, 16'hFFFF, 16'h0001, 9'd16},
        '{16'h0000, 16'hFFFF, 16'h8000, 9'd16},
        '{16'h00FF, 16'h0F0F, 16'h00FF, 9'd64},
        '{16'h1234, 16'h1234, 16'hFFFF, 9'd0},
        '{16'hF0F0, 16'h0000, 16'h0F0F, 9'd64},
        '{16'h8001, 16'h0000, 16'hFFFF, 9'd32},
        '{16'h0001, 16'h0000, 16'h0001, 9'd1},
        '{16'hFFFF, 16'hFFFE, 16'hFFFF, 9'd16},
        '{16'h0000, 16'hFFFF, 16'h7FFF, 9'd240},
        '{16'hC3C3, 16'h3C3C, 16'h0003, 9'd32}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [NB-1:0] cur_blk = '0;
    logic [NB-1:0] cand_blk = '0;
    logic          cost_valid;
    logic [8:0]    cost;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bbm_cost_unit #(.DIM(DIM)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .cur_blk    (cur_blk),
        .cand_blk   (cand_blk),
        .cost_valid (cost_valid),
        .cost       (cost)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] fill_rows(input logic [15:0] base,
                                                 input logic [15:0] alt,
                                                 input logic [15:0] mask);
        logic [NB-1:0] b;
        for (int r = 0; r < DIM; r++) begin
            b[r*DIM +: DIM] = mask[r] ? alt : base;
        end
        return b;
    endfunction

    function automatic int ref_cost(input logic [NB-1:0] a, input logic [NB-1:0] b);
        int n = 0;
        for (int i = 0; i < NB; i++) begin
            if (a[i] != b[i]) n++;
        end
        return n;
    endfunction

    function automatic logic [31:0] lfsr(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        logic [31:0]   seed;
        logic [NB-1:0] ra, rb;
        int            rexp [4];
        logic [8:0]    held;

        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 reset valid", int'(cost_valid), 0);
        chk("R8 reset cost", int'(cost), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R6: table streamed back to back
        for (int i = 0; i < NV + 2; i++) begin
            if (i < NV) begin
                cur_blk  = fill_rows(TBL[i].prow, TBL[i].prow, 16'h0000);
                cand_blk = fill_rows(TBL[i].prow, TBL[i].drow, TBL[i].rmask);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            if (i >= 2) begin
                chk("R6 stream valid", int'(cost_valid), 1);
                chk("R1 R3 table cost", int'(cost), int'(TBL[i-2].exp));
            end
            @(negedge clk);
        end
        chk("R7 idle after stream", int'(cost_valid), 0);

        // R5: single strobe latency
        cur_blk  = fill_rows(16'h0F00, 16'h0F00, 16'h0000);
        cand_blk = fill_rows(16'h0F00, 16'h0F0F, 16'h00F0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 not yet valid", int'(cost_valid), 0);
        @(negedge clk);
        chk("R5 valid at 2", int'(cost_valid), 1);
        chk("R5 cost", int'(cost), 16);
        held = cost;

        // R7: inputs ignored while in_valid low
        cur_blk  = '1;
        cand_blk = '0;
        repeat (3) @(negedge clk);
        chk("R7 ignored valid", int'(cost_valid), 0);
        chk("R7 cost held", int'(cost), int'(held));

        // R2 R4: full mismatch boundary
        cur_blk  = {NB{1'b1}};
        cand_blk = '0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R4 max cost", int'(cost), 256);

        // R1 R6: pseudo-random blocks back to back
        seed = 32'h1ACE_B00C;
        for (int k = 0; k < 6; k++) begin
            if (k < 4) begin
                for (int w = 0; w < NB/32; w++) begin
                    seed = lfsr(seed); ra[w*32 +: 32] = seed;
                    seed = lfsr(seed); rb[w*32 +: 32] = seed & {seed[15:0], seed[31:16]};
                end
                cur_blk  = ra;
                cand_blk = ra ^ rb;
                rexp[k]  = ref_cost(ra, ra ^ rb);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            if (k >= 2) begin
                chk("R6 random valid", int'(cost_valid), 1);
                chk("R1 random cost", int'(cost), rexp[k-2]);
            end
            @(negedge clk);
        end

        // R8: strobe during reset yields nothing
        cur_blk  = '1;
        cand_blk = '0;
        in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 cleared valid", int'(cost_valid), 0);
        chk("R8 cleared cost", int'(cost), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
            chk("R8 no result after reset", int'(cost_valid), 0);
            @(negedge clk);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule